// File: doc/BRIEF.md
# Converter Power-Up Control Sequencer

This block governs the reset and power state of an audio converter's digital core. An active-low reset returns every control register to its default, and the block then waits for all clock-stable indicators before it leaves its reset state. It then settles in a powered-down state with the power-down bit set. Software uses a small parallel register port to load the clocking mode and the low-power configuration while the core stays powered down.

A write that clears the power-down bit starts a timed power-up. The sequencer counts a parameterised number of frame-clock edges, which it samples through a synchroniser, and then raises the running indication. A write that sets the power-down bit during power-up or while running drops the core back to low power on the edge where that write lands. A clocking-mode write made while the core is active is stored and flagged. That value reaches the datapath only at the start of the next power-up.

Top module: `pwrseq_top`

## Requirements
- R1: While rst_n is low, the registers take their defaults (control register at address 0 reads 0x01, with the power-down bit at bit 0 set; mode register at address 1 and low-power register at address 2 read 0x00). In that condition state_oh is 4'b0001, pdn_flag and lowpwr_en are 1, running is 0 and mode_active is 0x00.
- R2: While any clk_ok bit is low, the block stays in the reset state (state_oh 4'b0001), ignores register writes and holds the registers at their defaults. Losing any clk_ok bit in any state returns the block to the reset state on the next clock edge.
- R3: Once rst_n is high and every clk_ok bit is high, the block enters the powered-down state (state_oh 4'b0010), with pdn_flag = 1 and lowpwr_en = 1.
- R4: In the powered-down state, a write (wr_en, addr, wdata) to address 0, 1 or 2 updates that register, and rdata returns the value at addr on the same cycle. Address 3 is unmapped: writes to it are ignored and it reads 0x00.
- R5: A write to address 0 with bit 0 clear moves the block to the power-up state (state_oh 4'b0100) on the same edge that stores the write. A write that keeps bit 0 set leaves the block powered down.
- R6: In the power-up state, running rises together with state_oh 4'b1000 on the edge that handles the WAIT_FRAMES-th rising edge of frame_clk (default 4). Before that edge running stays 0.
- R7: A write that sets bit 0 of address 0 during power-up or while running returns the block to the powered-down state on the edge where the write lands. If that write lands on the same edge as the final frame tick, power-down wins. The next power-up waits the full WAIT_FRAMES edges again.
- R8: lowpwr_en is 1 in every state except running. lp_level equals the register at address 2 while lowpwr_en is 1, and is 0x00 while running.
- R9: A write to address 1 during power-up or while running is stored and reads back, and mode_chg goes to 1, but mode_active keeps its value. On the edge that starts the next power-up, mode_active loads the register at address 1 and mode_chg clears.
- R10: state_oh always has exactly one bit set: bit 0 for reset, bit 1 for powered down, bit 2 for power-up and bit 3 for running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_ok | input | NUM_CLK | Per-clock stable indicators, all required high |
| frame_clk | input | 1 | Frame clock, synchronised internally |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for write and read |
| wdata | input | DATA_W | Register write data |
| rdata | output | DATA_W | Read data for addr |
| pdn_flag | output | 1 | Current power-down bit |
| lowpwr_en | output | 1 | Core held in low-power state |
| lp_level | output | DATA_W | Low-power configuration applied to the core |
| running | output | 1 | Converter datapath running |
| mode_active | output | DATA_W | Clocking mode in effect |
| mode_chg | output | 1 | A mode write awaits the next power cycle |
| state_oh | output | 4 | One-hot sequencer state |

## Verification
The power-down write and the frame tick that would finish power-up can arrive in the same cycle. The bench provokes this by raising frame_clk, counting the two synchroniser edges, and placing a write that sets the power-down bit in the cycle whose edge would otherwise enter running. The pass condition is that the block shows the powered-down state, with running low, immediately after that edge. A fresh power-up must then need all WAIT_FRAMES edges again before running is reached.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
   typedef enum logic [1:0] {
      ST_RESET = 2'd0,
      ST_PDOWN = 2'd1,
      ST_PWRUP = 2'd2,
      ST_RUN   = 2'd3
   } pseq_state_e;

   localparam int NUM_STATES = 4;
   localparam int REG_CTRL   = 0;
   localparam int REG_MODE   = 1;
   localparam int REG_LP     = 2;
   localparam int NUM_REGS   = 3;
endpackage

// File: rtl/pwrseq_regs.sv
module pwrseq_regs
   import pwrseq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 2,
   parameter int PD_BIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold_rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] mode_q,
   output logic [DATA_W-1:0] lp_q,
   output logic              pd_q,
   output logic              pd_nxt,
   output logic              mode_wr
);
   localparam logic [DATA_W-1:0] PD_MASK = DATA_W'(1) << PD_BIT;

   logic [DATA_W-1:0] regs_q [NUM_REGS];
   logic [NUM_REGS-1:0] wsel;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_REGS; gi++) begin : g_reg
         localparam logic [DATA_W-1:0] RST_VAL = (gi == REG_CTRL) ? PD_MASK : '0;
         assign wsel[gi] = wr_en && !hold_rst && (addr == ADDR_W'(gi));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               regs_q[gi] <= RST_VAL;
            end else if (hold_rst) begin
               regs_q[gi] <= RST_VAL;
            end else if (wsel[gi]) begin
               regs_q[gi] <= wdata;
            end
         end
      end
   endgenerate

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (addr == ADDR_W'(i)) rdata = regs_q[i];
      end
   end

   assign mode_q  = regs_q[REG_MODE];
   assign lp_q    = regs_q[REG_LP];
   assign pd_q    = regs_q[REG_CTRL][PD_BIT];
   assign mode_wr = wsel[REG_MODE];

   always_comb begin
      if (hold_rst)            pd_nxt = 1'b1;
      else if (wsel[REG_CTRL]) pd_nxt = wdata[PD_BIT];
      else                     pd_nxt = pd_q;
   end
endmodule

// File: rtl/pwrseq_frame_tick.sv
module pwrseq_frame_tick #(
   parameter int SYNC_STAGES = 2,
   parameter bit RISE_EDGE   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_in,
   output logic tick
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   cur;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], frame_in};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign cur = sync_q[SYNC_STAGES-1];

   generate
      if (RISE_EDGE) begin : g_rise
         assign tick = cur & ~prev_q;
      end else begin : g_fall
         assign tick = ~cur & prev_q;
      end
   endgenerate
endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
   import pwrseq_pkg::*;
#(
   parameter int WAIT_FRAMES = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clks_ok,
   input  logic        pd_nxt,
   input  logic        tick,
   output pseq_state_e state,
   output logic        start_pu
);
   localparam int CNT_W = $clog2(WAIT_FRAMES + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_FRAMES - 1);

   pseq_state_e state_q, state_d;
   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_RESET: state_d = ST_PDOWN;
         ST_PDOWN: if (!pd_nxt) state_d = ST_PWRUP;
         ST_PWRUP: begin
            if (pd_nxt)                     state_d = ST_PDOWN;
            else if (tick && cnt_q == LAST) state_d = ST_RUN;
         end
         ST_RUN:   if (pd_nxt) state_d = ST_PDOWN;
         default:  state_d = ST_RESET;
      endcase
      if (!clks_ok) state_d = ST_RESET;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RESET;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         if (state_q != ST_PWRUP) cnt_q <= '0;
         else if (tick)           cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign state    = state_q;
   assign start_pu = (state_q == ST_PDOWN) && (state_d == ST_PWRUP);
endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
   import pwrseq_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 2,
   parameter int NUM_CLK     = 3,
   parameter int WAIT_FRAMES = 4,
   parameter int SYNC_STAGES = 2,
   parameter int PD_BIT      = 0,
   parameter bit FRAME_RISE  = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_CLK-1:0]    clk_ok,
   input  logic                  frame_clk,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [DATA_W-1:0]     wdata,
   output logic [DATA_W-1:0]     rdata,
   output logic                  pdn_flag,
   output logic                  lowpwr_en,
   output logic [DATA_W-1:0]     lp_level,
   output logic                  running,
   output logic [DATA_W-1:0]     mode_active,
   output logic                  mode_chg,
   output logic [NUM_STATES-1:0] state_oh
);
   initial begin : g_param_chk
      assert (DATA_W > PD_BIT) else $error("PD_BIT outside DATA_W");
      assert ((1 << ADDR_W) >= NUM_REGS) else $error("ADDR_W too small");
      assert (WAIT_FRAMES >= 1) else $error("WAIT_FRAMES must be at least 1");
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
      assert (NUM_CLK >= 1) else $error("NUM_CLK must be at least 1");
   end

   logic              clks_ok;
   logic              hold_rst;
   logic [DATA_W-1:0] mode_q, lp_q;
   logic              pd_q, pd_nxt, mode_wr;
   logic              tick, start_pu;
   pseq_state_e       state;

   assign clks_ok  = &clk_ok;
   assign hold_rst = !clks_ok;

   pwrseq_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PD_BIT(PD_BIT)) u_regs (
      .clk(clk), .rst_n(rst_n), .hold_rst(hold_rst), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .mode_q(mode_q),
      .lp_q(lp_q), .pd_q(pd_q), .pd_nxt(pd_nxt), .mode_wr(mode_wr)
   );

   pwrseq_frame_tick #(.SYNC_STAGES(SYNC_STAGES), .RISE_EDGE(FRAME_RISE)) u_tick (
      .clk(clk), .rst_n(rst_n), .frame_in(frame_clk), .tick(tick)
   );

   pwrseq_fsm #(.WAIT_FRAMES(WAIT_FRAMES)) u_fsm (
      .clk(clk), .rst_n(rst_n), .clks_ok(clks_ok), .pd_nxt(pd_nxt),
      .tick(tick), .state(state), .start_pu(start_pu)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_active <= '0;
         mode_chg    <= 1'b0;
      end else if (hold_rst) begin
         mode_active <= '0;
         mode_chg    <= 1'b0;
      end else if (start_pu) begin
         mode_active <= mode_q;
         mode_chg    <= 1'b0;
      end else if (mode_wr && (state == ST_PWRUP || state == ST_RUN)) begin
         mode_chg    <= 1'b1;
      end
   end

   genvar gs;
   generate
      for (gs = 0; gs < NUM_STATES; gs++) begin : g_oh
         assign state_oh[gs] = (state == pseq_state_e'(gs));
      end
   endgenerate

   assign pdn_flag  = pd_q;
   assign running   = (state == ST_RUN);
   assign lowpwr_en = !running;
   assign lp_level  = lowpwr_en ? lp_q : '0;
endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk #(
   parameter int DATA_W  = 8,
   parameter int ADDR_W  = 2,
   parameter int NUM_CLK = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_CLK-1:0] clk_ok,
   input logic               wr_en,
   input logic [ADDR_W-1:0]  addr,
   input logic               wr_pd,
   input logic               pdn_flag,
   input logic               lowpwr_en,
   input logic [DATA_W-1:0]  lp_level,
   input logic               running,
   input logic [DATA_W-1:0]  mode_active,
   input logic               mode_chg,
   input logic [3:0]         state_oh
);
   // R10
   p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(state_oh) == 1);

   // R2
   p_clk_loss_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(&clk_ok) |=> state_oh[0] && pdn_flag);

   // R7
   p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == '0 && wr_pd && (&clk_ok) && (state_oh[2] || state_oh[3]))
      |=> state_oh[1] && !running);

   // R6
   p_run_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running) |-> $past(state_oh[2]) && !pdn_flag);

   // R8
   p_lowpwr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> !lowpwr_en && lp_level == '0 && !pdn_flag);

   // R9
   p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_oh[3] && $past(state_oh[3])) |-> $stable(mode_active));

   // R9
   p_mode_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state_oh[2]) |-> !mode_chg);
endmodule

bind pwrseq_top pwrseq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_CLK(NUM_CLK)) u_chk (
   .clk(clk), .rst_n(rst_n), .clk_ok(clk_ok), .wr_en(wr_en), .addr(addr),
   .wr_pd(wdata[PD_BIT]), .pdn_flag(pdn_flag), .lowpwr_en(lowpwr_en),
   .lp_level(lp_level), .running(running), .mode_active(mode_active),
   .mode_chg(mode_chg), .state_oh(state_oh)
);

// File: tb/tb_pwrseq_top.sv
module tb_pwrseq_top;
   localparam int CLK_PERIOD = 10;
   localparam int WAIT       = 4;
   localparam int NVEC       = 5;
   // {addr(4), wdata(8), expected readback(8)}, written in powered-down state
   localparam logic [19:0] VEC [NVEC] = '{
      {4'd1, 8'h5A, 8'h5A},
      {4'd2, 8'h33, 8'h33},
      {4'd3, 8'hFF, 8'h00},
      {4'd0, 8'h81, 8'h81},
      {4'd1, 8'hA5, 8'hA5}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] clk_ok = 3'b000;
   logic       frame_clk = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata, lp_level, mode_active;
   logic       pdn_flag, lowpwr_en, running, mode_chg;
   logic [3:0] state_oh;

   int checks = 0;
   int errors = 0;

   pwrseq_top #(.WAIT_FRAMES(WAIT)) dut (
      .clk(clk), .rst_n(rst_n), .clk_ok(clk_ok), .frame_clk(frame_clk),
      .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
      .pdn_flag(pdn_flag), .lowpwr_en(lowpwr_en), .lp_level(lp_level),
      .running(running), .mode_active(mode_active), .mode_chg(mode_chg),
      .state_oh(state_oh)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a);
      addr = a;
      #1;
   endtask

   task automatic pulse();
      @(negedge clk);
      frame_clk = 1'b1;
      repeat (4) @(negedge clk);
      frame_clk = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R1: reset values
      repeat (3) @(negedge clk);
      rd(2'd0);
      check("R1 state", state_oh, 4'b0001);
      check("R1 pdn", pdn_flag, 1);
      check("R1 lowpwr", lowpwr_en, 1);
      check("R1 running", running, 0);
      check("R1 ctrl", rdata, 8'h01);
      check("R1 mode_active", mode_active, 8'h00);

      // R2: clocks not yet stable
      rst_n = 1'b1;
      clk_ok = 3'b011;
      repeat (3) @(negedge clk);
      check("R2 hold", state_oh, 4'b0001);
      wr(2'd1, 8'h77);
      rd(2'd1);
      check("R2 write ignored", rdata, 8'h00);

      // R3
      clk_ok = 3'b111;
      repeat (2) @(negedge clk);
      check("R3 state", state_oh, 4'b0010);
      check("R3 pdn", pdn_flag, 1);
      check("R3 lowpwr", lowpwr_en, 1);

      // R4: table walk in powered-down state
      for (int i = 0; i < NVEC; i++) begin
         wr(VEC[i][17:16], VEC[i][15:8]);
         rd(VEC[i][17:16]);
         check("R4 readback", rdata, VEC[i][7:0]);
         check("R5 stays down", state_oh, 4'b0010);
      end
      check("R8 lp in pdown", lp_level, 8'h33);

      // R5: clear power-down bit
      wr(2'd0, 8'h00);
      check("R5 powering up", state_oh, 4'b0100);
      check("R9 mode latched", mode_active, 8'hA5);
      check("R8 lp in pwrup", lp_level, 8'h33);

      // R6
      for (int k = 0; k < WAIT - 1; k++) pulse();
      check("R6 not yet", running, 0);
      check("R6 still up", state_oh, 4'b0100);
      pulse();
      check("R6 running", running, 1);
      check("R6 state", state_oh, 4'b1000);
      check("R8 lowpwr off", lowpwr_en, 0);
      check("R8 lp zero", lp_level, 8'h00);

      // R9: mode write while running
      wr(2'd1, 8'h3C);
      rd(2'd1);
      check("R9 readback", rdata, 8'h3C);
      check("R9 active held", mode_active, 8'hA5);
      check("R9 flag", mode_chg, 1);

      // R7: power-down while running
      wr(2'd0, 8'h01);
      check("R7 abort run", state_oh, 4'b0010);
      check("R7 running low", running, 0);
      wr(2'd0, 8'h00);
      check("R9 new mode", mode_active, 8'h3C);
      check("R9 flag clear", mode_chg, 0);

      // R7: power-down on the same edge as the final tick
      for (int k = 0; k < WAIT - 1; k++) pulse();
      check("R7 pre-collision", state_oh, 4'b0100);
      @(negedge clk);
      frame_clk = 1'b1;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b1; addr = 2'd0; wdata = 8'h01;
      @(negedge clk);
      wr_en = 1'b0;
      check("R7 collision", state_oh, 4'b0010);
      check("R7 collision running", running, 0);
      repeat (4) @(negedge clk);
      frame_clk = 1'b0;
      repeat (4) @(negedge clk);
      check("R7 stays down", state_oh, 4'b0010);

      // R7: full wait again after abort
      wr(2'd0, 8'h00);
      for (int k = 0; k < WAIT - 1; k++) pulse();
      check("R7 restart count", state_oh, 4'b0100);
      pulse();
      check("R7 run after restart", state_oh, 4'b1000);

      // R2: clock loss while running
      @(negedge clk);
      clk_ok = 3'b101;
      @(negedge clk);
      check("R2 clock loss", state_oh, 4'b0001);
      rd(2'd1);
      check("R2 regs default", rdata, 8'h00);
      rd(2'd0);
      check("R2 ctrl default", rdata, 8'h01);
      clk_ok = 3'b111;
      repeat (2) @(negedge clk);
      check("R3 recover", state_oh, 4'b0010);

      // R1: asynchronous reset while running
      wr(2'd2, 8'h44);
      wr(2'd0, 8'h00);
      for (int k = 0; k < WAIT; k++) pulse();
      check("R10 run code", state_oh, 4'b1000);
      #2;
      rst_n = 1'b0;
      #1;
      rd(2'd2);
      check("R1 async reset", state_oh, 4'b0001);
      check("R1 lp reg", rdata, 8'h00);
      check("R1 running off", running, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule